// File: doc/BRIEF.md
# Video Input Formatter and Chroma Demultiplexer

This block sits between a parallel pixel source and a triple video DAC. It takes three 10-bit input ports (one for G/Y, one for B/Cb, one for R/Cr) on every clock. For each pixel it produces one aligned triple of luma/green, blue-difference/blue and red-difference/red. The block supports three packing formats: 4:4:4 on all three ports, 4:2:2 with luma on one port and interleaved chroma on a second port, and 4:2:2 with luma and chroma interleaved on a single port.

In the 4:2:2 formats the block pairs each chroma sample pair with the two consecutive luma samples it belongs to. It holds that chroma pair so that every output pixel carries a full triple. It does not filter or interpolate chroma. It also does not decode any timing codes embedded in the data. The chroma ordering is taken only from the active-video input: its low-to-high transition marks the clock edge that carries the first blue-difference sample.

Each format has its own fixed latency from input pins to outputs. 4:4:4 takes 8 clocks, two-port 4:2:2 takes 10 clocks and single-port 4:2:2 takes 11 clocks. An output strobe marks the cycles that carry a new pixel. In single-port mode the strobe is high every second clock and the outputs hold their value between strobes.

Top module: `vid_fmt_demux`

## Requirements
- R1: While `rst_ni` is low, `y_o`, `cb_o`, `cr_o` and `vld_o` are 0. The pipeline content after reset is zero until the first sampled pixel arrives at the outputs.
- R2: With `fmt_i` = 00 or 01, the values on `prt_y_i`, `prt_b_i` and `prt_r_i` at clock edge t appear on `y_o`, `cb_o` and `cr_o` after edge t+8. The two codes behave identically.
- R3: With `fmt_i` = 00 or 01, `vld_o` is high on every cycle once the pipeline has filled.
- R4: With `fmt_i` = 10, `prt_y_i` carries one luma sample per clock and `prt_r_i` carries Cb then Cr on alternate clocks. Cb is on the first edge with `act_i` high. The pixel whose luma was sampled at edge t appears after edge t+10, and both pixels of a pair carry that pair's Cb and Cr.
- R5: With `fmt_i` = 10, `vld_o` is high on every cycle once the pipeline has filled.
- R6: With `fmt_i` = 11, `prt_y_i` carries the repeating order Cb, Y, Cr, Y, with Cb on the first edge with `act_i` high. For a group whose Cb is sampled at edge t, the first luma appears after edge t+11 and the second after edge t+13. Both carry that group's Cb and Cr.
- R7: With `fmt_i` = 11, `vld_o` is high on alternate cycles, once per luma sample. On the cycles between strobes, all three data outputs hold their previous value.
- R8: Every low-to-high transition of `act_i` restarts the chroma ordering, whatever phase the previous sequence had reached.
- R9: `act_i` does not gate the data path. In 4:4:4 mode, samples taken while `act_i` is low still pass to the outputs with the normal latency.
- R10: Ports unused by the selected format are ignored: `prt_b_i` in mode 10, and both `prt_b_i` and `prt_r_i` in mode 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Packing format: 00 GBR 4:4:4, 01 YCbCr 4:4:4, 10 YCbCr 4:2:2 two-port, 11 YCbCr 4:2:2 one-port |
| act_i | input | 1 | Active-video window, high outside blanking; its rising edge sets chroma phase |
| prt_y_i | input | 10 | G/Y input port (multiplexed stream in one-port mode) |
| prt_b_i | input | 10 | B/Cb input port |
| prt_r_i | input | 10 | R/Cr input port (Cb/Cr stream in two-port mode) |
| y_o | output | 10 | Luma / green output |
| cb_o | output | 10 | Blue-difference / blue output |
| cr_o | output | 10 | Red-difference / red output |
| vld_o | output | 1 | New pixel on the outputs this cycle |

## Verification
If the phase counter misses an `act_i` rising edge, chroma is swapped with its neighbour or luma is taken from a chroma slot. The first pixel after the restart then shows the wrong chroma at the outputs, 10 or 11 cycles after the edge. A wrong tap or pipeline depth moves every output by whole cycles, so the first checked pixel of that mode already compares against the wrong sample. A wrong chroma-pair register shows up only on the second luma of a pair, two cycles after the first. A broken strobe or hold path in single-port mode appears on the very next cycle as a double strobe or as a data change without a strobe.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  typedef enum logic [1:0] {
    FMT_GBR444    = 2'b00,
    FMT_YCC444    = 2'b01,
    FMT_YCC422_2P = 2'b10,
    FMT_YCC422_1P = 2'b11
  } fmt_e;

  // assembly delay (input reg to assembled triple) per format
  localparam int unsigned ASM_DLY_444 = 1;
  localparam int unsigned ASM_DLY_2P  = 2;
  localparam int unsigned ASM_DLY_1P  = 3;

endpackage

// File: rtl/vfd_in_stage.sv
module vfd_in_stage
  import vfd_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    fmt_i,
  input  logic          act_i,
  input  logic [DW-1:0] prt_y_i,
  input  logic [DW-1:0] prt_b_i,
  input  logic [DW-1:0] prt_r_i,
  output fmt_e          fmt_o,
  output logic [1:0]    ph_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] r_o
);

  logic       act_q, act_qq;
  logic [1:0] ph_q;
  logic       start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_o  <= FMT_GBR444;
      act_q  <= 1'b0;
      act_qq <= 1'b0;
      y_o    <= '0;
      b_o    <= '0;
      r_o    <= '0;
    end else begin
      fmt_o  <= fmt_e'(fmt_i);
      act_q  <= act_i;
      act_qq <= act_q;
      y_o    <= prt_y_i;
      b_o    <= prt_b_i;
      r_o    <= prt_r_i;
    end
  end

  // sample held in y_o/b_o/r_o is phase 0 when it is the first one taken with act high
  assign start = act_q & ~act_qq;
  assign ph_o  = start ? 2'd0 : ph_q + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 2'd3;
    else         ph_q <= ph_o;
  end

endmodule

// File: rtl/vfd_assemble.sv
module vfd_assemble
  import vfd_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fmt_e          fmt_i,
  input  logic [1:0]    ph_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] r_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] cb_o,
  output logic [DW-1:0] cr_o,
  output logic          vld_o
);

  logic [DW-1:0] prev_y, prev_r, cb_hold, pair_cb, pair_cr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_y  <= '0;
      prev_r  <= '0;
      cb_hold <= '0;
      pair_cb <= '0;
      pair_cr <= '0;
      y_o     <= '0;
      cb_o    <= '0;
      cr_o    <= '0;
      vld_o   <= 1'b0;
    end else begin
      prev_y <= y_i;
      prev_r <= r_i;
      case (fmt_i)
        FMT_GBR444, FMT_YCC444: begin
          y_o   <= y_i;
          cb_o  <= b_i;
          cr_o  <= r_i;
          vld_o <= 1'b1;
        end
        FMT_YCC422_2P: begin
          vld_o <= 1'b1;
          y_o   <= prev_y;
          if (ph_i[0]) begin
            // Cr just arrived, Cb was the previous sample on the same port
            cb_o    <= prev_r;
            cr_o    <= r_i;
            pair_cb <= prev_r;
            pair_cr <= r_i;
          end else begin
            cb_o <= pair_cb;
            cr_o <= pair_cr;
          end
        end
        default: begin
          case (ph_i)
            2'd0: begin
              // second luma of previous group leaves, new Cb captured
              cb_hold <= y_i;
              y_o     <= prev_y;
              cb_o    <= pair_cb;
              cr_o    <= pair_cr;
              vld_o   <= 1'b1;
            end
            2'd2: begin
              y_o     <= prev_y;
              cb_o    <= cb_hold;
              cr_o    <= y_i;
              pair_cb <= cb_hold;
              pair_cr <= y_i;
              vld_o   <= 1'b1;
            end
            default: vld_o <= 1'b0;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/vfd_delay.sv
module vfd_delay #(
  parameter int unsigned W     = 31,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  d_i,
  input  logic [IW-1:0] sel_i,
  output logic [W-1:0]  q_o
);

  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[0] <= '0;
        else         stg[0] <= d_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[i] <= '0;
        else         stg[i] <= stg[i-1];
      end
    end
  end

  assign q_o = stg[sel_i];

endmodule

// File: rtl/vid_fmt_demux.sv
module vid_fmt_demux
  import vfd_pkg::*;
#(
  parameter int unsigned DW      = 10,
  parameter int unsigned LAT_444 = 8,
  parameter int unsigned LAT_2P  = 10,
  parameter int unsigned LAT_1P  = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    fmt_i,
  input  logic          act_i,
  input  logic [DW-1:0] prt_y_i,
  input  logic [DW-1:0] prt_b_i,
  input  logic [DW-1:0] prt_r_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] cb_o,
  output logic [DW-1:0] cr_o,
  output logic          vld_o
);

  localparam int unsigned TAP_444 = LAT_444 - ASM_DLY_444;
  localparam int unsigned TAP_2P  = LAT_2P - ASM_DLY_2P;
  localparam int unsigned TAP_1P  = LAT_1P - ASM_DLY_1P;
  localparam int unsigned TAP_MX  = (TAP_2P > TAP_1P) ? TAP_2P : TAP_1P;
  localparam int unsigned DEPTH   = (TAP_444 > TAP_MX) ? TAP_444 : TAP_MX;
  localparam int unsigned IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned PW      = 3 * DW + 1;

  fmt_e          fmt_q;
  logic [1:0]    ph;
  logic [DW-1:0] in_y, in_b, in_r;
  logic [DW-1:0] a_y, a_cb, a_cr;
  logic          a_vld;
  logic [IW-1:0] sel;
  logic [PW-1:0] tail_q;

  vfd_in_stage #(.DW(DW)) i_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fmt_i   (fmt_i),
    .act_i   (act_i),
    .prt_y_i (prt_y_i),
    .prt_b_i (prt_b_i),
    .prt_r_i (prt_r_i),
    .fmt_o   (fmt_q),
    .ph_o    (ph),
    .y_o     (in_y),
    .b_o     (in_b),
    .r_o     (in_r)
  );

  vfd_assemble #(.DW(DW)) i_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fmt_i  (fmt_q),
    .ph_i   (ph),
    .y_i    (in_y),
    .b_i    (in_b),
    .r_i    (in_r),
    .y_o    (a_y),
    .cb_o   (a_cb),
    .cr_o   (a_cr),
    .vld_o  (a_vld)
  );

  always_comb begin
    case (fmt_q)
      FMT_YCC422_2P: sel = IW'(TAP_2P - 1);
      FMT_YCC422_1P: sel = IW'(TAP_1P - 1);
      default:       sel = IW'(TAP_444 - 1);
    endcase
  end

  vfd_delay #(.W(PW), .DEPTH(DEPTH)) i_tail (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({a_vld, a_y, a_cb, a_cr}),
    .sel_i  (sel),
    .q_o    (tail_q)
  );

  assign {vld_o, y_o, cb_o, cr_o} = tail_q;

endmodule

// File: rtl/vfd_checker.sv
module vfd_checker #(
  parameter int unsigned DW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    fmt_i,
  input logic          act_i,
  input logic [DW-1:0] y_o,
  input logic [DW-1:0] cb_o,
  input logic [DW-1:0] cr_o,
  input logic          vld_o
);

  logic [1:0] fmt_d;
  logic       act_d;
  logic [3:0] quiet;
  logic       settled;

  // cycles since reset, format change or phase restart (saturating)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_d <= 2'b00;
      act_d <= 1'b0;
      quiet <= 4'd0;
    end else begin
      fmt_d <= fmt_i;
      act_d <= act_i;
      if ((fmt_i != fmt_d) || (act_i && !act_d)) quiet <= 4'd0;
      else if (quiet != 4'd15)                   quiet <= quiet + 4'd1;
    end
  end

  assign settled = (quiet >= 4'd14);

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!vld_o && y_o == '0 && cb_o == '0 && cr_o == '0)); // R1

  AST_FULL_RATE_444: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && !fmt_i[1] |-> vld_o); // R3

  AST_FULL_RATE_2P: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && fmt_i == 2'b10 |-> vld_o); // R5

  AST_STROBE_FALL_1P: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && fmt_i == 2'b11 && vld_o |=> !vld_o); // R7

  AST_STROBE_RISE_1P: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && fmt_i == 2'b11 && !vld_o |=> vld_o); // R7

  AST_HOLD_1P: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && fmt_i == 2'b11 && !vld_o |->
      ($stable(y_o) && $stable(cb_o) && $stable(cr_o))); // R7

endmodule

bind vid_fmt_demux vfd_checker #(.DW(DW)) i_vfd_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .fmt_i  (fmt_i),
  .act_i  (act_i),
  .y_o    (y_o),
  .cb_o   (cb_o),
  .cr_o   (cr_o),
  .vld_o  (vld_o)
);

// File: tb/test_vid_fmt_demux.sv
module test_vid_fmt_demux;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic       act = 1'b0;
  logic [9:0] py = '0, pb = '0, pr = '0;
  logic [9:0] y_o, cb_o, cr_o;
  logic       vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  vid_fmt_demux i_vid_fmt_demux (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .fmt_i   (fmt),
    .act_i   (act),
    .prt_y_i (py),
    .prt_b_i (pb),
    .prt_r_i (pr),
    .y_o     (y_o),
    .cb_o    (cb_o),
    .cr_o    (cr_o),
    .vld_o   (vld_o)
  );

  // captured outputs per format, index = edge + 8
  logic [9:0] ry [4][64];
  logic [9:0] rb [4][64];
  logic [9:0] rr [4][64];
  logic       rv [4][64];

  // {fmt, edge, y, cb, cr, vld, req}
  localparam int NV = 20;
  localparam logic [44:0] TBL [NV] = '{
    {2'd0, 8'd0,  10'd0,   10'd0,   10'd0,   1'b0, 4'd1},  // R1 pipeline empty
    {2'd0, 8'd8,  10'd100, 10'd300, 10'd600, 1'b1, 4'd2},  // R2
    {2'd0, 8'd9,  10'd101, 10'd301, 10'd601, 1'b1, 4'd3},  // R3
    {2'd0, 8'd28, 10'd120, 10'd320, 10'd620, 1'b1, 4'd9},  // R9 act low
    {2'd1, 8'd12, 10'd104, 10'd304, 10'd604, 1'b1, 4'd2},  // R2
    {2'd1, 8'd30, 10'd122, 10'd322, 10'd622, 1'b1, 4'd9},  // R9
    {2'd2, 8'd10, 10'd100, 10'd600, 10'd601, 1'b1, 4'd4},  // R4
    {2'd2, 8'd11, 10'd101, 10'd600, 10'd601, 1'b1, 4'd4},  // R4
    {2'd2, 8'd12, 10'd102, 10'd602, 10'd603, 1'b1, 4'd5},  // R5
    {2'd2, 8'd13, 10'd103, 10'd602, 10'd603, 1'b1, 4'd10}, // R10
    {2'd2, 8'd33, 10'd123, 10'd623, 10'd624, 1'b1, 4'd8},  // R8
    {2'd2, 8'd34, 10'd124, 10'd623, 10'd624, 1'b1, 4'd8},  // R8
    {2'd3, 8'd11, 10'd101, 10'd100, 10'd102, 1'b1, 4'd6},  // R6
    {2'd3, 8'd12, 10'd101, 10'd100, 10'd102, 1'b0, 4'd7},  // R7
    {2'd3, 8'd13, 10'd103, 10'd100, 10'd102, 1'b1, 4'd6},  // R6
    {2'd3, 8'd14, 10'd103, 10'd100, 10'd102, 1'b0, 4'd7},  // R7
    {2'd3, 8'd15, 10'd105, 10'd104, 10'd106, 1'b1, 4'd10}, // R10
    {2'd3, 8'd34, 10'd124, 10'd123, 10'd125, 1'b1, 4'd8},  // R8
    {2'd3, 8'd35, 10'd124, 10'd123, 10'd125, 1'b0, 4'd8},  // R8
    {2'd3, 8'd36, 10'd126, 10'd123, 10'd125, 1'b1, 4'd8}   // R8
  };

  task automatic drive(input int t);
    act = (t >= 0) && !(t >= 20 && t <= 22);  // restart at edge 23
    py  = 10'(100 + t);
    pb  = 10'(300 + t);
    pr  = 10'(600 + t);
  endtask

  task automatic run_stream(input int f);
    @(negedge clk);
    rst_ni = 1'b0;
    fmt    = 2'(f);
    act    = 1'b0;
    @(negedge clk);
    n_chk++;  // R1 reset clears outputs
    if (y_o !== 10'd0 || cb_o !== 10'd0 || cr_o !== 10'd0 || vld_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset fmt %0d: got y=%0d cb=%0d cr=%0d v=%0d exp 0 0 0 0",
               f, y_o, cb_o, cr_o, vld_o);
    end
    rst_ni = 1'b1;
    for (int t = -6; t <= 44; t++) begin
      drive(t);
      @(negedge clk);
      ry[f][t+8] = y_o;
      rb[f][t+8] = cb_o;
      rr[f][t+8] = cr_o;
      rv[f][t+8] = vld_o;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run not complete after %0d cycles, exp completion", 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 4; f++) run_stream(f);

    for (int i = 0; i < NV; i++) begin
      logic [44:0] e;
      int f, ed, rq;
      e  = TBL[i];
      f  = int'(e[44:43]);
      ed = int'(e[42:35]);
      rq = int'(e[3:0]);
      n_chk++;
      if (ry[f][ed+8] !== e[34:25] || rb[f][ed+8] !== e[24:15] ||
          rr[f][ed+8] !== e[14:5]  || rv[f][ed+8] !== e[4]) begin
        n_bad++;
        $display("FAIL R%0d fmt %0d edge %0d: got y=%0d cb=%0d cr=%0d v=%0d exp y=%0d cb=%0d cr=%0d v=%0d",
                 rq, f, ed, ry[f][ed+8], rb[f][ed+8], rr[f][ed+8], rv[f][ed+8],
                 e[34:25], e[24:15], e[14:5], e[4]);
      end
    end

    // R7: single-port strobe count over a settled window (edges 11..18)
    begin
      int cnt;
      cnt = 0;
      for (int t = 11; t <= 18; t++) cnt += int'(rv[3][t+8]);
      n_chk++;
      if (cnt != 4) begin
        n_bad++;
        $display("FAIL R7 strobe count edges 11..18: got %0d exp %0d", cnt, 4);
      end
    end

    // R3 / R5: full-rate strobe over edges 2..19
    for (int f = 0; f < 3; f++) begin
      int cnt;
      cnt = 0;
      for (int t = 2; t <= 19; t++) cnt += int'(rv[f][t+8]);
      n_chk++;
      if (cnt != 18) begin
        n_bad++;
        $display("FAIL R3/R5 fmt %0d strobe count: got %0d exp %0d", f, cnt, 18);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule